// File: doc/BRIEF.md
# Walking-Ones Link Shorts Tester

This block runs a bring-up test on a group of parallel serial link lanes. It looks for lanes that never arrive (opens) and for lanes bridged to a neighbour (shorts). While the test runs, the transmit side drives a single high lane at a time. Lane 0 goes first and stays high for a fixed run of bit times while every other lane is low. The high level then hands over to the next lane in ascending order. After the last lane has had its run, all lanes go low and a completion output rises.

The receive side gets the far-end copy of the pattern. It knows which lane should be high in each run and looks only at the middle bit times of each run, so a few bit times of lane skew do not cause false results. For each lane it keeps two sticky flags. The open flag sets when that lane reads low during its own run. The short flag sets when that lane reads high during another lane's run. The flags clear when a new test starts and keep their values after the test is switched off, so they can be read later.

The test runs only while both the training enable and the shorts-mode select are high. The random-data select has no effect on this block.

Top module: `lane_shorts_tester`

## Requirements
- R1: During reset and in the first cycle after it, all transmit lanes are 0, `done` is 0 and every open and short flag is 0.
- R2: When `train_en` or `shorts_mode` is 0, every transmit lane is 0 and `done` is 0 in the following cycle.
- R3: The value of `random_mode` never changes the transmit pattern, `done` or the flags.
- R4: In the first cycle after both enables are sampled high, bit `tx_data[0]` alone is 1. Exactly one lane is 1 for RUN_LEN consecutive cycles, and the high lane then steps to the next higher index.
- R5: In the cycle after the last lane's run ends, `done` is 1 and every transmit lane is 0. This state holds until the mode is disabled.
- R6: `open_flag[i]` sets when `rx_data[i]` reads 0 at a window bit time of lane i's own run. Window bit times are positions GUARD through RUN_LEN-1-GUARD, counting from 0 within the run.
- R7: `short_flag[i]` sets when `rx_data[i]` reads 1 at a window bit time of another lane's run.
- R8: Receive values at bit times outside the window are ignored, so a receive delay of up to GUARD bit times on a fault-free link leaves all flags 0.
- R9: Flags are sticky. They clear in the first cycle of a new test and keep their values while idle, in the completion state and after the mode is disabled.
- R10: Dropping an enable in the middle of a walk returns all lanes to 0 in the next cycle. The following test starts again from lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Synchronous active-low reset |
| train_en | input | 1 | Link training enable |
| shorts_mode | input | 1 | Selects the shorts test (runs when this and `train_en` are both 1) |
| random_mode | input | 1 | Random-data select, ignored by this block |
| rx_data | input | LANES | Received lane values from the far end |
| tx_data | output | LANES | Transmit lane values |
| open_flag | output | LANES | Sticky per-lane open detection |
| short_flag | output | LANES | Sticky per-lane short detection |
| done | output | 1 | High once every lane has completed its run |

## Verification
If the lane index or bit counter is wrong, it shows up on `tx_data` as a run that is too long or too short, or as a lane that is skipped or repeated. The bench compares every cycle of the walk against the ideal pattern, so a bad counter step is seen within one run of RUN_LEN cycles. A wrong window bound or a bad flag update shows on the flag outputs at `done`. The bench drives a loopback model with injected opens, adjacent-lane bridges and up to GUARD cycles of delay, so the error appears there. Flags that fail to clear or fail to hold show at the start of the next test or one cycle after disable.

// File: rtl/lst_pkg.sv
// Shared types for the walking-ones shorts tester.
package lst_pkg;
    // Phase of one test pass.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DONE = 2'd2
    } walk_state_t;
endpackage

// File: rtl/walk_seq.sv
// walk_seq: keeps the lane index and the bit-time count for the walking-ones test.
// It decides when a test starts, walks, completes and aborts.
// Assumes: LANES >= 2, RUN_LEN a power of two, 2*GUARD < RUN_LEN, GUARD >= 1.
module walk_seq
    import lst_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int RUN_LEN = 16,
    parameter int GUARD   = 4,
    localparam int LANE_W = $clog2(LANES),
    localparam int BIT_W  = $clog2(RUN_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    output logic              walking_o,
    output logic              done_o,
    output logic              start_o,
    output logic              in_win_o,
    output logic [LANE_W-1:0] lane_o
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(RUN_LEN - 1);
    localparam logic [BIT_W-1:0]  WIN_LO    = BIT_W'(GUARD);
    localparam logic [BIT_W-1:0]  WIN_HI    = BIT_W'(RUN_LEN - 1 - GUARD);

    walk_state_t       state_q;
    logic [LANE_W-1:0] lane_q;
    logic [BIT_W-1:0]  bit_q;

    // Phase, lane and bit-time counters; leaving active always returns to idle at lane 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
            bit_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_q <= ST_WALK;
                    lane_q  <= '0;
                    bit_q   <= '0;
                end
                ST_WALK: begin
                    if (bit_q == LAST_BIT) begin
                        bit_q <= '0;
                        if (lane_q == LAST_LANE) state_q <= ST_DONE;
                        else                     lane_q  <= lane_q + 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    // Phase decode and the skew-tolerant sampling window.
    always_comb begin
        walking_o = (state_q == ST_WALK);
        done_o    = (state_q == ST_DONE);
        start_o   = (state_q == ST_IDLE) && active_i;
        in_win_o  = walking_o && (bit_q >= WIN_LO) && (bit_q <= WIN_HI);
        lane_o    = lane_q;
    end

    // R4: at the end of a run the next lane takes over.
    a_r4_lane_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && walking_o && bit_q == LAST_BIT && lane_q != LAST_LANE)
            |=> (walking_o && lane_q == $past(lane_q) + 1'b1 && bit_q == '0));

    // R10: every start begins at lane 0, bit time 0.
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (walking_o && lane_q == '0 && bit_q == '0));

    // R5: completion holds while the mode stays enabled.
    a_r5_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && active_i) |=> done_o);

    // R2: disabling the mode leaves the sequencer idle.
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (!walking_o && !done_o));
endmodule

// File: rtl/lane_driver.sv
// lane_driver: turns the sequencer's lane index into the transmit pattern.
// Exactly one lane is high while walking; all lanes are low otherwise.
// Assumes: lane_i is below LANES whenever walking_i is high.
module lane_driver #(
    parameter int LANES   = 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              walking_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [LANES-1:0]  tx_o
);
    // One comparator per lane drives that lane's level.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb tx_o[g] = walking_i && (lane_i == LANE_W'(g));
    end
endmodule

// File: rtl/walk_checker.sv
// walk_checker: compares received lanes with the expected walking pattern inside
// the window and keeps sticky per-lane open and short flags.
// Assumes: exp_i is the transmit pattern of the current bit time; start_i and
// in_win_i are never high together.
module walk_checker #(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             in_win_i,
    input  logic [LANES-1:0] exp_i,
    input  logic [LANES-1:0] rx_i,
    output logic [LANES-1:0] open_o,
    output logic [LANES-1:0] short_o
);
    logic [LANES-1:0] miss_w;
    logic [LANES-1:0] extra_w;

    // Mismatch vectors: expected-high lanes read low, expected-low lanes read high.
    always_comb begin
        miss_w  = exp_i & ~rx_i;
        extra_w = ~exp_i & rx_i;
    end

    // Sticky flags: cleared on a new start, accumulated only inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            open_o  <= '0;
            short_o <= '0;
        end else if (in_win_i) begin
            open_o  <= open_o | miss_w;
            short_o <= short_o | extra_w;
        end
    end

    // R6: a missing high in the window is recorded for that lane.
    a_r6_open_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win_i && miss_w != '0) |=> ((open_o & $past(miss_w)) == $past(miss_w)));

    // R7: an unexpected high in the window is recorded for that lane.
    a_r7_short_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win_i && extra_w != '0) |=> ((short_o & $past(extra_w)) == $past(extra_w)));

    // R8, R9: outside the window and without a start the flags do not move.
    a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_win_i && !start_i) |=> ($stable(open_o) && $stable(short_o)));

    // R9: a start leaves every flag clear.
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (open_o == '0 && short_o == '0));
endmodule

// File: rtl/lane_shorts_tester.sv
// lane_shorts_tester: walking-ones opens/shorts test for a group of link lanes.
// It combines the sequencer, the transmit decode and the receive checker.
// Assumes: rx_data arrives within GUARD bit times of tx_data.
module lane_shorts_tester #(
    parameter int LANES   = 8,
    parameter int RUN_LEN = 16,
    parameter int GUARD   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             train_en,
    input  logic             shorts_mode,
    input  logic             random_mode,
    input  logic [LANES-1:0] rx_data,
    output logic [LANES-1:0] tx_data,
    output logic [LANES-1:0] open_flag,
    output logic [LANES-1:0] short_flag,
    output logic             done
);
    localparam int LANE_W = $clog2(LANES);

    logic              active;
    logic              walking;
    logic              start;
    logic              in_win;
    logic [LANE_W-1:0] lane;

    // Test runs only with both enables; the random-data select takes no part.
    always_comb active = train_en && shorts_mode;

    walk_seq #(.LANES(LANES), .RUN_LEN(RUN_LEN), .GUARD(GUARD)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active),
        .walking_o (walking),
        .done_o    (done),
        .start_o   (start),
        .in_win_o  (in_win),
        .lane_o    (lane)
    );

    lane_driver #(.LANES(LANES)) u_drv (
        .walking_i (walking),
        .lane_i    (lane),
        .tx_o      (tx_data)
    );

    walk_checker #(.LANES(LANES)) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .in_win_i(in_win),
        .exp_i   (tx_data),
        .rx_i    (rx_data),
        .open_o  (open_flag),
        .short_o (short_flag)
    );

    // R5: the completion state drives no lane.
    a_r5_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tx_data == '0));

    // R3: an enabled test proceeds whatever the random-data select is.
    a_r3_rand_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (active && random_mode) |=> (walking || done));

    // R4: at most one lane is driven at any time.
    a_r4_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_data));
endmodule

// File: tb/lane_shorts_tester_bench.sv
module lane_shorts_tester_bench;
    localparam int LANES   = 8;
    localparam int RUN_LEN = 16;
    localparam int GUARD   = 4;
    localparam int TOTAL   = LANES * RUN_LEN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic train_en = 1'b0;
    logic shorts_mode = 1'b0;
    logic random_mode = 1'b0;
    logic [LANES-1:0] rx_data = '0;
    logic [LANES-1:0] tx_data, open_flag, short_flag;
    logic done;

    logic [LANES-1:0] f_open = '0;
    logic [LANES-1:0] f_bridge = '0;
    int f_delay = 0;
    logic [LANES-1:0] hist [0:GUARD];
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    lane_shorts_tester #(.LANES(LANES), .RUN_LEN(RUN_LEN), .GUARD(GUARD)) u_lane_shorts_tester (
        .clk(clk), .rst_n(rst_n), .train_en(train_en), .shorts_mode(shorts_mode),
        .random_mode(random_mode), .rx_data(rx_data), .tx_data(tx_data),
        .open_flag(open_flag), .short_flag(short_flag), .done(done)
    );

    // Link model: bridge bit k joins lanes k and k+1 as wired-OR; an open lane reads 0.
    function automatic logic [LANES-1:0] link_model(input logic [LANES-1:0] t,
                                                   input logic [LANES-1:0] op,
                                                   input logic [LANES-1:0] br);
        logic [LANES-1:0] r;
        for (int k = 0; k < LANES; k++) begin
            logic v;
            v = t[k];
            if (k > 0 && br[k-1]) v = v | t[k-1];
            if (k < LANES - 1 && br[k]) v = v | t[k+1];
            r[k] = op[k] ? 1'b0 : v;
        end
        return r;
    endfunction

    function automatic logic [LANES-1:0] exp_tx(input int k);
        if (k < TOTAL) return LANES'(1) << (k / RUN_LEN);
        return '0;
    endfunction

    function automatic logic [LANES-1:0] exp_short(input logic [LANES-1:0] op,
                                                  input logic [LANES-1:0] br);
        logic [LANES-1:0] r;
        for (int k = 0; k < LANES; k++) begin
            logic b;
            b = (k < LANES - 1) ? br[k] : 1'b0;
            if (k > 0) b = b | br[k-1];
            r[k] = b && !op[k];
        end
        return r;
    endfunction

    // Far-end delay line and fault model, updated away from the active edge.
    initial for (int i = 0; i <= GUARD; i++) hist[i] = '0;
    always @(negedge clk) begin
        for (int i = GUARD; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = tx_data;
        rx_data = link_model(hist[f_delay], f_open, f_bridge);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One complete test pass with the given faults and delay.
    task automatic run_walk(input logic [LANES-1:0] op, input logic [LANES-1:0] br,
                            input int dly, input bit jitter);
        int errs;
        logic [LANES-1:0] o_hold, s_hold;
        f_open = op; f_bridge = br; f_delay = dly;
        @(negedge clk);
        train_en = 1'b1; shorts_mode = 1'b1;
        errs = 0;
        for (int k = 0; k < TOTAL; k++) begin
            @(negedge clk);
            if (k == 0)
                check(open_flag == '0 && short_flag == '0, "R9", "flags clear at start",
                      {open_flag, short_flag}, 0);
            if (tx_data !== exp_tx(k) || done !== 1'b0) errs++;
            if (jitter) random_mode = 1'($urandom % 2);
        end
        check(errs == 0, "R4", "walk pattern (R3 random select toggled)", errs, 0);
        @(negedge clk);
        check(done === 1'b1 && tx_data === '0, "R5", "done with lanes low", {done, tx_data}, {1'b1, 8'h0});
        check(open_flag === op, "R6", "open flags", open_flag, op);
        check(short_flag === exp_short(op, br), "R7", "short flags", short_flag, exp_short(op, br));
        errs = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            random_mode = ~random_mode;
            if (done !== 1'b1 || tx_data !== '0) errs++;
        end
        check(errs == 0, "R5", "completion holds", errs, 0);
        o_hold = open_flag; s_hold = short_flag;
        shorts_mode = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && tx_data === '0, "R2", "disabled outputs", {done, tx_data}, 0);
        check(open_flag === o_hold && short_flag === s_hold, "R9", "flags held after disable",
              {open_flag, short_flag}, {o_hold, s_hold});
        train_en = 1'b0;
        repeat (GUARD + 2) @(negedge clk);
    endtask

    initial begin
        int errs;
        void'($urandom(32'h5eed_0001));
        repeat (3) @(negedge clk);
        check(tx_data === '0 && done === 1'b0 && open_flag === '0 && short_flag === '0,
              "R1", "reset state", {done, tx_data, open_flag, short_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_data === '0 && done === 1'b0, "R1", "first cycle after reset", {done, tx_data}, 0);

        // R2: one enable without the other does nothing.
        train_en = 1'b1; shorts_mode = 1'b0; random_mode = 1'b1;
        errs = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (tx_data !== '0 || done !== 1'b0) errs++;
        end
        train_en = 1'b0; shorts_mode = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (tx_data !== '0 || done !== 1'b0) errs++;
        end
        check(errs == 0, "R2", "single enable keeps lanes low", errs, 0);
        shorts_mode = 1'b0; random_mode = 1'b0;
        @(negedge clk);

        // Clean link, no delay and full delay (R8).
        run_walk('0, '0, 0, 1'b0);
        run_walk('0, '0, GUARD, 1'b1);
        check(open_flag === '0 && short_flag === '0, "R8", "skew of GUARD gives no flags",
              {open_flag, short_flag}, 0);

        // Directed faults at both edge lanes and one mid bridge.
        run_walk(8'h81, 8'h08, 2, 1'b1);

        // R10: abort in the middle, then restart from lane 0.
        f_open = '0; f_bridge = '0; f_delay = 1;
        @(negedge clk);
        train_en = 1'b1; shorts_mode = 1'b1;
        repeat (40) @(negedge clk);
        train_en = 1'b0;
        @(negedge clk);
        check(tx_data === '0 && done === 1'b0, "R10", "abort drops lanes", {done, tx_data}, 0);
        train_en = 1'b1;
        errs = 0;
        for (int k = 0; k < TOTAL; k++) begin
            @(negedge clk);
            if (k == 0) check(tx_data === 8'h01, "R10", "restart at lane 0", tx_data, 8'h01);
            if (tx_data !== exp_tx(k)) errs++;
        end
        check(errs == 0, "R10", "restarted walk pattern", errs, 0);
        @(negedge clk);
        check(done === 1'b1 && open_flag === '0 && short_flag === '0, "R10", "restarted walk clean",
              {done, open_flag, short_flag}, {1'b1, 16'h0});
        train_en = 1'b0; shorts_mode = 1'b0;
        repeat (GUARD + 2) @(negedge clk);

        // Constrained random faults and delays.
        for (int n = 0; n < 12; n++) begin
            logic [LANES-1:0] op, br;
            op = LANES'($urandom & $urandom & $urandom);
            br = LANES'($urandom & $urandom) & {1'b0, {(LANES-1){1'b1}}};
            run_walk(op, br, int'($urandom % (GUARD + 1)), 1'b1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #2000000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule